// File: doc/BRIEF.md
# Receive Character Buffer with Line Status

This block sits on the receive side of a serial port, between the shift register that assembles characters and the software-visible read port. Each time the shift register finishes a character, it gives one strobe. The strobe carries the data byte and a flag that says whether the parity check failed. The block queues the characters in a first-in first-out store. It returns the oldest character on a data read. It also keeps a small status word with three bits: one says that data is waiting, one records an overrun, and one records a parity fault.

An overrun happens when a character arrives and the queue is already full. In that case the stored characters are kept and the new arrival is thrown away. Each queued character carries its own parity tag. The parity status bit is raised when a tagged character becomes the oldest entry in the queue. Both error bits clear when the status word is read. If a new error event occurs in the same cycle as the read, the event takes priority and the bit stays set.

Top module: `rx_status_buf`

## Requirements
- R1: After reset, the status word is 3'b000 and `rd_data` is 0.
- R2: Characters come out in the order they were accepted. A data read on a non-empty queue loads the oldest character into `rd_data` at the next clock edge and removes it from the queue.
- R3: Status bit 0 (data ready) is 1 exactly when the queue holds at least one character.
- R4: The queue holds up to DEPTH characters (default 16) without loss.
- R5: Status bit 1 (overrun) is set when a character strobe arrives while the queue is full. This is judged on the state before that edge, and applies even if a data read happens in the same cycle. The incoming character is discarded and the stored characters are unchanged.
- R6: A status read clears the overrun bit.
- R7: Each stored character keeps its parity tag. Status bit 2 (parity) is set at the edge where a tagged character becomes the oldest entry. This happens either when it is written into an empty queue, or when the entry ahead of it is read out.
- R8: A status read clears the parity bit. The bit stays cleared while the same character remains the oldest entry.
- R9: When an overrun event or a tagged-head event falls in the same cycle as a status read, that bit stays set.
- R10: A data read on an empty queue leaves `rd_data`, the queue and the status word unchanged.
- R11: The status word is packed as {parity, overrun, ready}, in bits 2, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_valid | input | 1 | An assembled character is present this cycle |
| chr_data | input | DATA_W | Assembled character |
| chr_par_bad | input | 1 | The parity of the assembled character failed |
| data_rd | input | 1 | Read and remove the oldest character |
| stat_rd | input | 1 | Status word is read this cycle (clears the error bits) |
| rd_data | output | DATA_W | Last character read out |
| stat_word | output | 3 | {parity, overrun, ready} |

## Verification
The bench goes after several corner cases:
- It fills the queue to its limit and keeps sending characters. A design that overwrote the oldest entry, or accepted a character into a full queue, would return a wrong read order.
- It sends a character and reads out an entry in the same cycle while the queue is full. This exposes a design that judged "full" after the read.
- It places tagged characters behind untagged ones. A design that latched the parity error at write time, rather than when the character reaches the head, would raise the bit too early.
- It reads the status word in the same cycle as a new error event. A design where the clear won would drop the bit.
- It reads from an empty queue. A design that advanced its pointers would corrupt the data that follows.

// File: rtl/rxsb_pkg.sv
package rxsb_pkg;
   localparam int STAT_W     = 3;
   localparam int STAT_READY = 0;
   localparam int STAT_OVR   = 1;
   localparam int STAT_PAR   = 2;
   localparam int FLAG_N     = 2;
   localparam int FLAG_OVR   = 0;
   localparam int FLAG_PAR   = 1;
endpackage

// File: rtl/rxsb_fifo.sv
module rxsb_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_tag,
   input  logic              rd_req,
   output logic [DATA_W-1:0] head_data,
   output logic              empty,
   output logic              full,
   output logic              pop,
   output logic              head_bad_arrive
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam bit POW2  = ((DEPTH & (DEPTH - 1)) == 0);

   if (DATA_W < 1) begin : g_bad_width
      $error("rxsb_fifo: DATA_W must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("rxsb_fifo: DEPTH must be at least 2");
   end

   logic [DATA_W-1:0] data_mem [DEPTH];
   logic [DEPTH-1:0]  tag_mem;
   logic [PTR_W-1:0]  rptr, wptr, rptr_inc, wptr_inc;
   logic [CNT_W-1:0]  count;
   logic              push;

   if (POW2) begin : g_wrap_pow2
      assign rptr_inc = rptr + PTR_W'(1);
      assign wptr_inc = wptr + PTR_W'(1);
   end else begin : g_wrap_cmp
      assign rptr_inc = (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + PTR_W'(1);
      assign wptr_inc = (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + PTR_W'(1);
   end

   assign empty = (count == '0);
   assign full  = (count == CNT_W'(DEPTH));
   assign push  = wr_req && !full;
   assign pop   = rd_req && !empty;

   assign head_data = data_mem[rptr];

   always_comb begin
      head_bad_arrive = 1'b0;
      if (pop && count > CNT_W'(1)) begin
         head_bad_arrive = tag_mem[rptr_inc];
      end else if (push && (empty || (pop && count == CNT_W'(1)))) begin
         head_bad_arrive = wr_tag;
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         data_mem[wptr] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_mem <= '0;
         rptr    <= '0;
         wptr    <= '0;
         count   <= '0;
      end else begin
         if (push) begin
            tag_mem[wptr] <= wr_tag;
            wptr          <= wptr_inc;
         end
         if (pop) begin
            rptr <= rptr_inc;
         end
         case ({push, pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   a_r5_full_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && full && !rd_req) |=> full);
   a_r10_empty_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && empty && !wr_req) |=> empty);
endmodule

// File: rtl/rxsb_sticky.sv
module rxsb_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr_req,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (set_evt) begin
         flag <= 1'b1;
      end else if (clr_req) begin
         flag <= 1'b0;
      end
   end

   a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> flag);
   a_r6_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !set_evt) |=> !flag);
   a_r1_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_evt && !clr_req) |=> $stable(flag));
endmodule

// File: rtl/rx_status_buf.sv
module rx_status_buf
   import rxsb_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chr_valid,
   input  logic [DATA_W-1:0] chr_data,
   input  logic              chr_par_bad,
   input  logic              data_rd,
   input  logic              stat_rd,
   output logic [DATA_W-1:0] rd_data,
   output logic [STAT_W-1:0] stat_word
);
   if (DEPTH > 4096) begin : g_bad_depth
      $error("rx_status_buf: DEPTH too large");
   end

   logic [DATA_W-1:0] head_data;
   logic              empty, full, pop, head_bad_arrive;
   logic [FLAG_N-1:0] flag_evt, flag_q;

   rxsb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk             (clk),
      .rst_n           (rst_n),
      .wr_req          (chr_valid),
      .wr_data         (chr_data),
      .wr_tag          (chr_par_bad),
      .rd_req          (data_rd),
      .head_data       (head_data),
      .empty           (empty),
      .full            (full),
      .pop             (pop),
      .head_bad_arrive (head_bad_arrive)
   );

   assign flag_evt[FLAG_OVR] = chr_valid && full;
   assign flag_evt[FLAG_PAR] = head_bad_arrive;

   for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
      rxsb_sticky u_sticky (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_evt (flag_evt[i]),
         .clr_req (stat_rd),
         .flag    (flag_q[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (pop) begin
         rd_data <= head_data;
      end
   end

   always_comb begin
      stat_word             = '0;
      stat_word[STAT_READY] = !empty;
      stat_word[STAT_OVR]   = flag_q[FLAG_OVR];
      stat_word[STAT_PAR]   = flag_q[FLAG_PAR];
   end

   a_r3_ready_after_char: assert property (@(posedge clk) disable iff (!rst_n)
      chr_valid |=> stat_word[STAT_READY]);
   a_r5_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_valid && full) |=> stat_word[STAT_OVR]);
   a_r10_empty_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !stat_word[STAT_READY]) |=> $stable(rd_data));
endmodule

// File: tb/rx_status_buf_bench.sv
module rx_status_buf_bench;
   localparam int DW  = 8;
   localparam int DEP = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chr_valid = 1'b0;
   logic [DW-1:0] chr_data = '0;
   logic          chr_par_bad = 1'b0;
   logic          data_rd = 1'b0;
   logic          stat_rd = 1'b0;
   logic [DW-1:0] rd_data;
   logic [2:0]    stat_word;

   always #10 clk = ~clk;

   rx_status_buf #(.DATA_W(DW), .DEPTH(DEP)) u_rx_status_buf (
      .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
      .chr_par_bad(chr_par_bad), .data_rd(data_rd), .stat_rd(stat_rd),
      .rd_data(rd_data), .stat_word(stat_word)
   );

   int         n_cmp = 0;
   int         n_bad = 0;
   bit         done  = 1'b0;
   string      cur   = "R1";
   logic [8:0] q[$];
   logic [DW-1:0] e_rd = '0;
   logic       e_ovr = 1'b0;
   logic       e_par = 1'b0;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare();
      chk(cur, "stat_word", 32'(stat_word), 32'({e_par, e_ovr, q.size() != 0}));
      chk(cur, "rd_data", 32'(rd_data), 32'(e_rd));
   endtask

   // driver: applies one cycle and updates the expected queue
   task automatic step(input logic v, input logic [DW-1:0] d, input logic pb,
                       input logic dr, input logic sr);
      int  sz;
      bit  fl, po, pu, pe, oe;
      chr_valid = v; chr_data = d; chr_par_bad = pb; data_rd = dr; stat_rd = sr;
      @(posedge clk);
      sz = q.size();
      fl = (sz == DEP);
      po = dr && sz != 0;
      pu = v && !fl;
      oe = v && fl;
      pe = 1'b0;
      if (po && sz >= 2)                       pe = q[1][8];
      else if (pu && (sz == 0 || (po && sz == 1))) pe = pb;
      if (po) begin
         e_rd = q[0][DW-1:0];
         void'(q.pop_front());
      end
      if (pu) q.push_back({pb, d});
      e_ovr = oe ? 1'b1 : (sr ? 1'b0 : e_ovr);
      e_par = pe ? 1'b1 : (sr ? 1'b0 : e_par);
      @(negedge clk);
      chr_valid = 1'b0; data_rd = 1'b0; stat_rd = 1'b0; chr_par_bad = 1'b0;
      compare();
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired in %s", cur);
         report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      cur = "R1";
      compare();
      rst_n = 1'b1;
      @(negedge clk);
      compare();

      cur = "R3";
      step(1, 8'hA5, 0, 0, 0);
      step(0, 0, 0, 0, 0);
      cur = "R2";
      step(0, 0, 0, 1, 0);

      cur = "R4";
      for (int i = 0; i < DEP; i++) step(1, DW'(8'h10 + i), 0, 0, 0);
      cur = "R5";
      step(1, 8'hEE, 0, 0, 0);
      step(1, 8'hEF, 0, 0, 0);
      cur = "R6";
      step(0, 0, 0, 0, 1);
      cur = "R5";
      step(1, 8'hDD, 0, 1, 0);
      cur = "R6";
      step(0, 0, 0, 0, 1);
      cur = "R2";
      for (int i = 0; i < DEP - 1; i++) step(0, 0, 0, 1, 0);

      cur = "R10";
      step(0, 0, 0, 1, 0);
      step(0, 0, 0, 1, 0);

      cur = "R7";
      step(1, 8'h30, 0, 0, 0);
      step(1, 8'h31, 1, 0, 0);
      step(1, 8'h32, 0, 0, 0);
      step(1, 8'h33, 1, 0, 0);
      step(0, 0, 0, 1, 0);
      cur = "R8";
      step(0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0);
      cur = "R7";
      step(0, 0, 0, 1, 0);
      step(0, 0, 0, 1, 0);
      cur = "R8";
      step(0, 0, 0, 0, 1);
      step(0, 0, 0, 1, 0);
      cur = "R7";
      step(1, 8'h44, 1, 0, 0);
      cur = "R8";
      step(0, 0, 0, 0, 1);
      step(0, 0, 0, 1, 0);

      cur = "R9";
      for (int i = 0; i < DEP; i++) step(1, DW'(8'h50 + i), (i == 1), 0, 0);
      step(1, 8'h77, 0, 0, 1);
      step(1, 8'h78, 0, 1, 1);
      cur = "R11";
      chk(cur, "packed word", 32'(stat_word), 32'(3'b111));
      cur = "R6";
      step(0, 0, 0, 0, 1);
      cur = "R2";
      for (int i = 0; i < DEP; i++) step(0, 0, 0, 1, 0);
      cur = "R3";
      step(0, 0, 0, 0, 0);

      done = 1'b1;
      report();
   end
endmodule